// File: doc/BRIEF.md
# Cumulative Diagnostic Logger

This block keeps a permanent, growing record of every diagnostic status flag that has ever been raised. When its enable input is high it first loads the stored record from external non-volatile memory, one byte per request. It then watches the live status flags. Whenever a flag is set live but is missing from the record, the block asks for the record byte to be rewritten with that flag added. The stored record only ever gains bits, so it builds up across power cycles and is not cleared when the status is read.

Memory traffic goes through a request/acknowledge port to a separate memory-access engine, which handles the serial protocol. A request holds its address, direction and data until the engine acknowledges it. Reads carry their data back on the acknowledge cycle. Record byte `i` lives at memory address `BASE_ADDR + i`, and byte `i` of the live status bus is `liveStatus[8*i +: 8]`. The command-busy flag is not latched, so it is never logged.

Top module: `diag_record_logger`

## Requirements
- R1: After reset, `memReq` and `loggerReady` are low and `recordOut` is zero.
- R2: While `logEn` has never been high, no request is issued and `loggerReady` stays low.
- R3: Once `logEn` is high, the block reads addresses 0x75, 0x76 and 0x77 in ascending order with `memWe`=0. Each read's `memRdata` on its acknowledge cycle goes into record byte 0, 1 and 2. `loggerReady` rises after the last read and then stays high.
- R4: After startup, a live flag that is absent from the record causes a write (`memWe`=1) to that byte's address. The write data is the old record byte OR the new flags.
- R5: A live flag that is already in the record causes no write.
- R6: When a write is acknowledged, its bits join `recordOut`. A live flag falling never removes a bit from the record.
- R7: When new flags appear in several bytes in the same cycle, one write is issued per byte, in ascending address order. Each write starts only after the previous one is acknowledged.
- R8: A flag that appears while a write is outstanding is held as pending. It is written by a later write, in ascending byte order, after the current write is acknowledged.
- R9: Bit 7 of byte 2 (address 0x77, the command-busy flag) never triggers a write.
- R10: A request keeps its address, direction and data stable until it is acknowledged. After a write is acknowledged, `memReq` is low for at least one cycle.
- R11: While `logEn` is low after startup, new flags are not captured and no write starts. When `logEn` returns, a flag that is still set live is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| logEn | input | 1 | Logging enable configuration bit |
| liveStatus | input | 24 | Live status flags, byte i at bits 8i+7..8i |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 8 | Memory byte address |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid with memAck |
| memAck | input | 1 | One-cycle acknowledge of the current request |
| recordOut | output | 24 | Current cumulative record, byte i at bits 8i+7..8i |
| loggerReady | output | 1 | Startup read finished, monitoring active |

## Verification
The hardest case to reach is a new flag that appears in a byte whose write is already outstanding. The flag must miss the snapshot being written, survive the acknowledge, and then produce a second write to the same address ahead of a higher byte. The bench stretches the memory engine's latency to ten cycles, waits until it sees the write request on the port, and only then raises a second flag in the same byte and one in the next byte. It then checks that the three writes arrive in the right order with the right data.

// File: rtl/diag_log_pkg.sv
package diag_log_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_MON,
    ST_WRITE
  } logState_t;

  typedef struct packed {
    logic capRead;
    logic snapWrite;
    logic commit;
    logic watch;
  } dpStrobe_t;
endpackage

// File: rtl/diag_log_dp.sv
module diag_log_dp
  import diag_log_pkg::*;
#(
  parameter int NUM_BYTES = 3,
  parameter int BYTE_W = 8,
  parameter int IDX_W = 2,
  parameter logic [NUM_BYTES*BYTE_W-1:0] LOG_MASK = '1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   strobe,
  input  logic [IDX_W-1:0]            idx,
  input  logic [NUM_BYTES*BYTE_W-1:0] liveStatus,
  input  logic [BYTE_W-1:0]           memRdata,
  output logic                        pendingAny,
  output logic [IDX_W-1:0]            lowIdx,
  output logic [BYTE_W-1:0]           wrData,
  output logic [NUM_BYTES*BYTE_W-1:0] record
);
  localparam int TOTAL_W = NUM_BYTES * BYTE_W;

  logic [NUM_BYTES-1:0][BYTE_W-1:0] stored;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] pending;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] newBits;
  logic [BYTE_W-1:0] curBits;
  logic [BYTE_W-1:0] wrDataQ;
  logic [BYTE_W-1:0] storedSel;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_bytes
    assign newBits[g] = liveStatus[g*BYTE_W +: BYTE_W] & LOG_MASK[g*BYTE_W +: BYTE_W]
                        & ~stored[g] & ~pending[g];
    assign record[g*BYTE_W +: BYTE_W] = stored[g];
  end

  always_comb begin
    lowIdx = '0;
    pendingAny = 1'b0;
    for (int i = NUM_BYTES - 1; i >= 0; i--) begin
      if (|pending[i]) begin
        lowIdx = IDX_W'(i);
        pendingAny = 1'b1;
      end
    end
  end

  always_comb begin
    storedSel = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (idx == IDX_W'(i)) storedSel = stored[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stored  <= '0;
      pending <= '0;
      curBits <= '0;
      wrDataQ <= '0;
    end else begin
      for (int i = 0; i < NUM_BYTES; i++) begin
        logic hit;
        hit = (idx == IDX_W'(i));
        if (strobe.capRead && hit) stored[i] <= memRdata;
        else if (strobe.commit && hit) stored[i] <= stored[i] | curBits;
        pending[i] <= (pending[i] & ~((strobe.commit && hit) ? curBits : '0))
                      | (strobe.watch ? newBits[i] : '0);
        if (strobe.snapWrite && lowIdx == IDX_W'(i)) begin
          curBits <= pending[i];
          wrDataQ <= stored[i] | pending[i];
        end
      end
    end
  end

  assign wrData = wrDataQ;

  AST_WDATA_HAS_NEW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> ((wrDataQ & ~storedSel) != '0));  // R4
  AST_WDATA_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> ((wrDataQ & storedSel) == storedSel));  // R6
  AST_NO_MASKED_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (TOTAL_W'(pending) & ~LOG_MASK) == '0);  // R9
  AST_RECORD_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capRead |=> ((stored & $past(stored)) == $past(stored)));  // R6
endmodule

// File: rtl/diag_log_ctrl.sv
module diag_log_ctrl
  import diag_log_pkg::*;
#(
  parameter int NUM_BYTES = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             logEn,
  input  logic             memAck,
  input  logic             pendingAny,
  input  logic [IDX_W-1:0] lowIdx,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] idx,
  output logic             memReq,
  output logic             memWe,
  output logic             ready
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  logState_t state, nextState;
  logic [IDX_W-1:0] idxQ, nextIdx;

  always_comb begin
    strobe = '0;
    memReq = 1'b0;
    memWe = 1'b0;
    nextState = state;
    nextIdx = idxQ;
    unique case (state)
      ST_IDLE: begin
        if (logEn) begin
          nextState = ST_READ;
          nextIdx = '0;
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.capRead = 1'b1;
          if (idxQ == LAST_IDX) nextState = ST_MON;
          else nextIdx = idxQ + 1'b1;
        end
      end
      ST_MON: begin
        strobe.watch = logEn;
        if (logEn && pendingAny) begin
          strobe.snapWrite = 1'b1;
          nextIdx = lowIdx;
          nextState = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe = 1'b1;
        strobe.watch = logEn;
        if (memAck) begin
          strobe.commit = 1'b1;
          nextState = ST_MON;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idxQ <= '0;
    end else begin
      state <= nextState;
      idxQ <= nextIdx;
    end
  end

  assign idx = idxQ;
  assign ready = (state == ST_MON) || (state == ST_WRITE);

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(idxQ)));  // R10
  AST_WRITE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck) |=> !memReq);  // R10
  AST_READ_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capRead && idxQ != LAST_IDX) |=> (idxQ == $past(idxQ) + 1'b1));  // R3
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);  // R3
endmodule

// File: rtl/diag_record_logger.sv
module diag_record_logger
  import diag_log_pkg::*;
#(
  parameter int NUM_BYTES = 3,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 8,
  parameter int BASE_ADDR = 'h75,
  parameter logic [NUM_BYTES*BYTE_W-1:0] LOG_MASK = {1'b0, {(NUM_BYTES*BYTE_W-1){1'b1}}}
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        logEn,
  input  logic [NUM_BYTES*BYTE_W-1:0] liveStatus,
  output logic                        memReq,
  output logic                        memWe,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [BYTE_W-1:0]           memWdata,
  input  logic [BYTE_W-1:0]           memRdata,
  input  logic                        memAck,
  output logic [NUM_BYTES*BYTE_W-1:0] recordOut,
  output logic                        loggerReady
);
  localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  dpStrobe_t strobe;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lowIdx;
  logic pendingAny;

  diag_log_ctrl #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .logEn(logEn), .memAck(memAck),
    .pendingAny(pendingAny), .lowIdx(lowIdx), .strobe(strobe), .idx(idx),
    .memReq(memReq), .memWe(memWe), .ready(loggerReady)
  );

  diag_log_dp #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W), .IDX_W(IDX_W),
                .LOG_MASK(LOG_MASK)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idx(idx),
    .liveStatus(liveStatus), .memRdata(memRdata), .pendingAny(pendingAny),
    .lowIdx(lowIdx), .wrData(memWdata), .record(recordOut)
  );

  assign memAddr = ADDR_W'(BASE_ADDR) + ADDR_W'(idx);
endmodule

// File: tb/diag_record_logger_tb.sv
module diag_record_logger_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic logEn = 1'b0;
  logic [23:0] liveStatus = '0;
  logic memReq, memWe, loggerReady;
  logic [7:0] memAddr, memWdata;
  logic [7:0] memRdata = '0;
  logic memAck = 1'b0;
  logic [23:0] recordOut;

  always #10 clk = ~clk;

  diag_record_logger dut_i (
    .clk(clk), .rstN(rstN), .logEn(logEn), .liveStatus(liveStatus),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .recordOut(recordOut),
    .loggerReady(loggerReady)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] mem [3];
  int lat = 1;
  int cnt = 0;
  int txnCount = 0;
  logic [7:0] txnAddr [32];
  logic [7:0] txnData [32];
  logic txnWe [32];
  int stabErr = 0, gapErr = 0;
  logic [7:0] holdAddr, holdData;
  logic holdWe;
  bit gapFlag = 0;

  // memory engine model, works on the falling edge
  always @(negedge clk) begin
    if (gapFlag && memReq) gapErr++;
    gapFlag = 0;
    if (memAck) begin
      memAck = 1'b0;
      cnt = 0;
    end else if (memReq) begin
      if (cnt == 0) begin
        holdAddr = memAddr; holdData = memWdata; holdWe = memWe;
      end else if (holdAddr != memAddr || holdWe != memWe || (memWe && holdData != memWdata)) begin
        stabErr++;
      end
      cnt++;
      if (cnt >= lat) begin
        memAck = 1'b1;
        if (txnCount < 32) begin
          txnAddr[txnCount] = memAddr;
          txnData[txnCount] = memWdata;
          txnWe[txnCount] = memWe;
        end
        txnCount++;
        if (memAddr >= 8'h75 && memAddr <= 8'h77) begin
          memRdata = mem[memAddr - 8'h75];
          if (memWe) mem[memAddr - 8'h75] = memWdata;
        end
        gapFlag = memWe;
        cnt = 0;
      end
    end else begin
      cnt = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitTxn(input int n);
    for (int i = 0; i < 400 && txnCount < n; i++) @(negedge clk);
  endtask

  task automatic chkTxn(input string req, input int k, input logic [7:0] a,
                        input logic [7:0] d, input logic we);
    chk(req, {24'h0, txnAddr[k]}, {24'h0, a});
    chk(req, {31'h0, txnWe[k]}, {31'h0, we});
    if (we) chk(req, {24'h0, txnData[k]}, {24'h0, d});
  endtask

  task automatic tReset();
    repeat (3) @(negedge clk);
    chk("R1 memReq", {31'h0, memReq}, 0);
    chk("R1 ready", {31'h0, loggerReady}, 0);
    chk("R1 record", {8'h0, recordOut}, 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 no txn", txnCount, 0);
    chk("R2 ready", {31'h0, loggerReady}, 0);
  endtask

  task automatic tStartup();
    logEn = 1'b1;
    for (int i = 0; i < 200 && !loggerReady; i++) @(negedge clk);
    chk("R3 ready", {31'h0, loggerReady}, 1);
    chk("R3 count", txnCount, 3);
    chkTxn("R3 rd0", 0, 8'h75, 8'h00, 1'b0);
    chkTxn("R3 rd1", 1, 8'h76, 8'h00, 1'b0);
    chkTxn("R3 rd2", 2, 8'h77, 8'h00, 1'b0);
    chk("R3 record", {8'h0, recordOut}, 32'h041001);
  endtask

  task automatic tKnown();
    liveStatus[12] = 1'b1;  // byte 1 bit 4, already recorded
    repeat (20) @(negedge clk);
    chk("R5 no write", txnCount, 3);
  endtask

  task automatic tNew();
    liveStatus[3] = 1'b1;
    waitTxn(4);
    chkTxn("R4 write", 3, 8'h75, 8'h09, 1'b1);
    repeat (3) @(negedge clk);
    chk("R6 record", {24'h0, recordOut[7:0]}, 8'h09);
    liveStatus[3] = 1'b0;
    repeat (10) @(negedge clk);
    chk("R6 kept", {24'h0, recordOut[7:0]}, 8'h09);
    chk("R6 no write", txnCount, 4);
  endtask

  task automatic tMulti();
    liveStatus[16] = 1'b1; liveStatus[7] = 1'b1; liveStatus[9] = 1'b1;
    waitTxn(7);
    chkTxn("R7 w0", 4, 8'h75, 8'h89, 1'b1);
    chkTxn("R7 w1", 5, 8'h76, 8'h12, 1'b1);
    chkTxn("R7 w2", 6, 8'h77, 8'h05, 1'b1);
    repeat (3) @(negedge clk);
    chk("R7 record", {8'h0, recordOut}, 32'h051289);
  endtask

  task automatic tMerge();
    lat = 10;
    liveStatus[6] = 1'b1;
    for (int i = 0; i < 100 && !memReq; i++) @(negedge clk);
    liveStatus[5] = 1'b1; liveStatus[8] = 1'b1;
    waitTxn(10);
    chkTxn("R8 first", 7, 8'h75, 8'hC9, 1'b1);
    chkTxn("R8 merged", 8, 8'h75, 8'hE9, 1'b1);
    chkTxn("R8 next", 9, 8'h76, 8'h13, 1'b1);
    repeat (3) @(negedge clk);
    chk("R8 record", {8'h0, recordOut}, 32'h0513E9);
    lat = 2;
  endtask

  task automatic tBusy();
    liveStatus[23] = 1'b1;
    repeat (30) @(negedge clk);
    chk("R9 busy ignored", txnCount, 10);
    chk("R9 record", {31'h0, recordOut[23]}, 0);
  endtask

  task automatic tProtocol();
    chk("R10 stable", stabErr, 0);
    chk("R10 gap", gapErr, 0);
  endtask

  task automatic tDisable();
    logEn = 1'b0;
    @(negedge clk);
    liveStatus[15] = 1'b1;
    repeat (20) @(negedge clk);
    chk("R11 no write", txnCount, 10);
    chk("R11 record", {24'h0, recordOut[15:8]}, 8'h13);
    logEn = 1'b1;
    waitTxn(11);
    chkTxn("R11 resumed", 10, 8'h76, 8'h93, 1'b1);
  endtask

  initial begin
    mem[0] = 8'h01; mem[1] = 8'h10; mem[2] = 8'h04;
    tReset();
    tStartup();
    tKnown();
    tNew();
    tMulti();
    tMerge();
    tBusy();
    tDisable();
    repeat (5) @(negedge clk);
    tProtocol();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule